// File: doc/BRIEF.md
# Masked Vector Gather/Scatter Line Coalescer

This block carries out one vector gather or scatter on behalf of a scalar pipeline. The scalar side hands over a base address, one signed index per lane, a lane mask and (for a scatter) a source vector, and pulses `start_i`. The block turns each index into a lane address. It then walks the mask one cache line at a time: on every step it picks the lowest lane still pending and issues a single line-sized access for that lane's line. That one access serves every other pending lane in the same line.

When a gather response returns, each served lane pulls its element out of the line at its own word slot and writes only its own element of the destination vector image. For a scatter, the served lanes are merged into one line write with per-byte enables. The served lanes then leave the mask. The block raises `done_o` once the mask is empty, so gathers and scatters with good locality need far fewer cache accesses than elements.

Top module: `gather_coalescer`

## Requirements
- R1: Lane i's byte address is `base_i + sign_extend(index_i[i*IDX_W +: IDX_W]) * ELEM_BYTES`, modulo 2^ADDR_W. The low log2(ELEM_BYTES) bits of `base_i` are ignored, so elements are always element-aligned.
- R2: Each access targets the line of the lowest-numbered lane still pending. `req_line_addr_o` equals that lane's address with its low log2(LINE_BYTES) bits cleared. That lane is always served by the access.
- R3: One access serves every pending lane whose address bits above the line offset match the access line. The number of accesses for an instruction equals the number of distinct lines among its active lanes.
- R4: For a gather, each served lane i loads the ELEM_BYTES-byte word of the returned line at word slot `addr[log2(LINE_BYTES)-1 : log2(ELEM_BYTES)]`. The line is little-endian: byte b sits in `rsp_data_i[8*b +: 8]`. The word goes into `dest_o[i*ELEM_W +: ELEM_W]`. Lanes not served keep their previous value.
- R5: The mask bits of served lanes clear when the response is taken, and the next access follows only after that. `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. `done_o` is a one-cycle pulse in the cycle after the final response is taken.
- R6: For a scatter, `req_write_o` is 1. Each served lane's source element is placed at its word slot in `req_wdata_o`, using the same little-endian layout as R4, with the matching ELEM_BYTES bits of `req_be_o` set and all other enables clear. If two served lanes map to the same word, the higher-numbered lane's data is written. `dest_o` is unchanged by a scatter.
- R7: If the mask is all zeros at start, `done_o` is high in the very next cycle and no access is issued.
- R8: A request holds `req_valid_o` and its line address until `req_ready_i` is seen. A response is only taken after the request's handshake.
- R9: `start_i` is ignored while `busy_o` is high. A start pulse during an instruction changes neither its accesses nor its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an instruction (accepted when idle) |
| store_i | input | 1 | 1 = scatter, 0 = gather |
| base_i | input | ADDR_W | Shared base byte address |
| index_i | input | LANES*IDX_W | Signed per-lane element indices |
| mask_i | input | LANES | Active lane mask |
| src_i | input | LANES*ELEM_W | Scatter source vector |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Mask drained (one-cycle pulse) |
| dest_o | output | LANES*ELEM_W | Destination vector register image |
| req_valid_o | output | 1 | Line access request valid |
| req_ready_i | input | 1 | Cache accepts the request |
| req_write_o | output | 1 | Request is a line write |
| req_line_addr_o | output | ADDR_W | Line-aligned access address |
| req_wdata_o | output | 8*LINE_BYTES | Merged write line |
| req_be_o | output | LINE_BYTES | Byte enables for the write |
| rsp_valid_i | input | 1 | Response (read data or write acknowledge) |
| rsp_data_i | input | 8*LINE_BYTES | Returned line data |

## Verification
The bench builds the block with 8 lanes, 4-byte elements, 16-byte lines, a 10-bit address and 6-bit indices. Each line then holds only four elements, and the whole 1 KiB address space fits in a bench memory. Because of this, wrap-around of negative indices, instructions that span one to eight lines, and same-word scatter conflicts all occur often in a long sweep. The bench recomputes the expected line order, access count, gathered words and post-scatter memory from scratch. A cache model with random ready stalls and response latency surrounds the block.

// File: rtl/gsc_pkg.sv
package gsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_FIN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/gsc_word_addr.sv
// Per-lane address formation in element (word) units.
module gsc_word_addr #(
  parameter int LANES = 8,
  parameter int IDX_W = 16,
  parameter int WA_W  = 30,
  parameter int WIDX  = 4
) (
  input  logic [WA_W-1:0]               base_w,
  input  logic [LANES*IDX_W-1:0]        index_flat,
  output logic [LANES*(WA_W-WIDX)-1:0]  tag_flat,
  output logic [LANES*WIDX-1:0]         slot_flat
);
  localparam int TAG_W = WA_W - WIDX;

  // Word address: base plus the sign-extended index (scaling is implicit
  // because everything is counted in elements).
  function automatic logic [WA_W-1:0] lane_word(input logic [WA_W-1:0] b,
                                                input logic [IDX_W-1:0] ix);
    logic signed [IDX_W-1:0] sx;
    sx = $signed(ix);
    return b + WA_W'(sx);
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [WA_W-1:0] word_addr;
    assign word_addr = lane_word(base_w, index_flat[l*IDX_W +: IDX_W]);
    assign tag_flat[l*TAG_W +: TAG_W] = word_addr[WA_W-1:WIDX];
    assign slot_flat[l*WIDX +: WIDX]  = word_addr[WIDX-1:0];
  end
endmodule

// File: rtl/gsc_line_pick.sv
// Find-first pending lane and the set of pending lanes sharing its line.
module gsc_line_pick #(
  parameter int LANES  = 8,
  parameter int TAG_W  = 26,
  parameter int LIDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0]       pend_mask,
  input  logic [LANES*TAG_W-1:0] tag_flat,
  output logic                   any_o,
  output logic [LIDX_W-1:0]      first_o,
  output logic [TAG_W-1:0]       tag_o,
  output logic [LANES-1:0]       hit_o
);
  function automatic logic [LIDX_W-1:0] lowest_set(input logic [LANES-1:0] m);
    logic [LIDX_W-1:0] r;
    r = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (m[i]) r = LIDX_W'(i);
    end
    return r;
  endfunction

  assign any_o   = |pend_mask;
  assign first_o = lowest_set(pend_mask);
  assign tag_o   = tag_flat[first_o*TAG_W +: TAG_W];

  for (genvar l = 0; l < LANES; l++) begin : g_cmp
    assign hit_o[l] = pend_mask[l] && (tag_flat[l*TAG_W +: TAG_W] == tag_o);
  end
endmodule

// File: rtl/gsc_line_lanes.sv
// Scatter merge into one line and gather extraction from one line.
module gsc_line_lanes #(
  parameter int LANES  = 8,
  parameter int ELEM_W = 32,
  parameter int WIDX   = 4
) (
  input  logic [LANES-1:0]                  hit,
  input  logic [LANES*WIDX-1:0]             slot_flat,
  input  logic [LANES*ELEM_W-1:0]           src_flat,
  input  logic [(ELEM_W<<WIDX)-1:0]         line_i,
  output logic [(ELEM_W<<WIDX)-1:0]         pack_data,
  output logic [((ELEM_W/8)<<WIDX)-1:0]     pack_be,
  output logic [LANES*ELEM_W-1:0]           pick_flat
);
  localparam int EB = ELEM_W / 8;

  function automatic logic [ELEM_W-1:0] elem_at(input logic [(ELEM_W<<WIDX)-1:0] ln,
                                                input logic [WIDX-1:0] s);
    return ln[s*ELEM_W +: ELEM_W];
  endfunction

  for (genvar l = 0; l < LANES; l++) begin : g_pick
    assign pick_flat[l*ELEM_W +: ELEM_W] = elem_at(line_i, slot_flat[l*WIDX +: WIDX]);
  end

  // Ascending lane order: a later (higher) lane overwrites an earlier one.
  always_comb begin
    pack_data = '0;
    pack_be   = '0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l]) begin
        pack_data[slot_flat[l*WIDX +: WIDX]*ELEM_W +: ELEM_W] = src_flat[l*ELEM_W +: ELEM_W];
        pack_be[slot_flat[l*WIDX +: WIDX]*EB +: EB]            = '1;
      end
    end
  end
endmodule

// File: rtl/gather_coalescer.sv
module gather_coalescer
  import gsc_pkg::*;
#(
  parameter int LANES      = 8,
  parameter int ADDR_W     = 32,
  parameter int IDX_W      = 16,
  parameter int ELEM_BYTES = 4,
  parameter int LINE_BYTES = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          store_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [LANES*IDX_W-1:0]        index_i,
  input  logic [LANES-1:0]              mask_i,
  input  logic [LANES*ELEM_BYTES*8-1:0] src_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [LANES*ELEM_BYTES*8-1:0] dest_o,
  output logic                          req_valid_o,
  input  logic                          req_ready_i,
  output logic                          req_write_o,
  output logic [ADDR_W-1:0]             req_line_addr_o,
  output logic [LINE_BYTES*8-1:0]       req_wdata_o,
  output logic [LINE_BYTES-1:0]         req_be_o,
  input  logic                          rsp_valid_i,
  input  logic [LINE_BYTES*8-1:0]       rsp_data_i
);
  localparam int ELEM_W = 8 * ELEM_BYTES;
  localparam int ESH    = $clog2(ELEM_BYTES);
  localparam int LOFF   = $clog2(LINE_BYTES);
  localparam int WIDX   = LOFF - ESH;
  localparam int WA_W   = ADDR_W - ESH;
  localparam int TAG_W  = ADDR_W - LOFF;
  localparam int LIDX_W = $clog2(LANES);

  seq_state_t                 state_q;
  logic [WA_W-1:0]            base_w_q;
  logic [LANES*IDX_W-1:0]     index_q;
  logic [LANES-1:0]           mask_q;
  logic [LANES*ELEM_W-1:0]    src_q;
  logic                       store_q;
  logic [LANES*ELEM_W-1:0]    dest_q;

  // Named internal events.
  logic [LANES*TAG_W-1:0]     tag_flat;
  logic [LANES*WIDX-1:0]      slot_flat;
  logic                       pend_any;
  logic [LIDX_W-1:0]          first_lane;
  logic [TAG_W-1:0]           acc_tag;
  logic [LANES-1:0]           lane_hit;
  logic [LANES-1:0]           mask_left;
  logic [LANES*ELEM_W-1:0]    pick_flat;
  logic [LINE_BYTES*8-1:0]    pack_data;
  logic [LINE_BYTES-1:0]      pack_be;
  logic                       start_take;
  logic                       step_done;

  gsc_word_addr #(
    .LANES(LANES), .IDX_W(IDX_W), .WA_W(WA_W), .WIDX(WIDX)
  ) u_addr (
    .base_w     (base_w_q),
    .index_flat (index_q),
    .tag_flat   (tag_flat),
    .slot_flat  (slot_flat)
  );

  gsc_line_pick #(
    .LANES(LANES), .TAG_W(TAG_W), .LIDX_W(LIDX_W)
  ) u_pick (
    .pend_mask (mask_q),
    .tag_flat  (tag_flat),
    .any_o     (pend_any),
    .first_o   (first_lane),
    .tag_o     (acc_tag),
    .hit_o     (lane_hit)
  );

  gsc_line_lanes #(
    .LANES(LANES), .ELEM_W(ELEM_W), .WIDX(WIDX)
  ) u_lanes (
    .hit       (lane_hit),
    .slot_flat (slot_flat),
    .src_flat  (src_q),
    .line_i    (rsp_data_i),
    .pack_data (pack_data),
    .pack_be   (pack_be),
    .pick_flat (pick_flat)
  );

  assign start_take = (state_q == ST_IDLE) && start_i;
  assign step_done  = (state_q == ST_WAIT) && rsp_valid_i;
  assign mask_left  = mask_q & ~lane_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      base_w_q <= '0;
      index_q  <= '0;
      mask_q   <= '0;
      src_q    <= '0;
      store_q  <= 1'b0;
      dest_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_take) begin
            base_w_q <= base_i[ADDR_W-1:ESH];
            index_q  <= index_i;
            mask_q   <= mask_i;
            src_q    <= src_i;
            store_q  <= store_i;
            state_q  <= (mask_i == '0) ? ST_FIN : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (req_ready_i) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rsp_valid_i) begin
            mask_q <= mask_left;
            for (int l = 0; l < LANES; l++) begin
              if (!store_q && lane_hit[l])
                dest_q[l*ELEM_W +: ELEM_W] <= pick_flat[l*ELEM_W +: ELEM_W];
            end
            state_q <= (mask_left != '0) ? ST_ISSUE : ST_FIN;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign done_o          = (state_q == ST_FIN);
  assign dest_o          = dest_q;
  assign req_valid_o     = (state_q == ST_ISSUE);
  assign req_write_o     = store_q;
  assign req_line_addr_o = {acc_tag, {LOFF{1'b0}}};
  assign req_wdata_o     = pack_data;
  assign req_be_o        = store_q ? pack_be : '0;

  // R2: the lane that named the line is served by the step.
  a_r2_first_served: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> !mask_q[$past(first_lane)]);

  // R3: a request always serves at least one pending lane and no idle lane.
  a_r3_hits_pending: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (pend_any && lane_hit != '0 && (lane_hit & ~mask_q) == '0));

  // R5: every completed step strictly drains the mask.
  a_r5_mask_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    step_done |=> ($countones(mask_q) < $past($countones(mask_q))));

  // R5: completion only with an empty mask.
  a_r5_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (mask_q == '0));

  // R7: an empty mask finishes at once without a request.
  a_r7_empty_fin: assert property (@(posedge clk) disable iff (!rst_n)
    (start_take && mask_i == '0) |=> (done_o && !req_valid_o));

  // R8: a stalled request keeps its address.
  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_line_addr_o)));
endmodule

// File: tb/gather_coalescer_test.sv
`timescale 1ns/1ps
module gather_coalescer_test;
  localparam int LANES = 8, ADDR_W = 10, IDX_W = 6, EBY = 4, LBY = 16;
  localparam int EW = 8 * EBY, LW = 8 * LBY, MEMSZ = 1 << ADDR_W;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                   rst_n, start_i, store_i;
  logic [ADDR_W-1:0]      base_i;
  logic [LANES*IDX_W-1:0] index_i;
  logic [LANES-1:0]       mask_i;
  logic [LANES*EW-1:0]    src_i;
  logic                   busy_o, done_o, req_valid_o, req_ready_i, req_write_o;
  logic [LANES*EW-1:0]    dest_o;
  logic [ADDR_W-1:0]      req_line_addr_o;
  logic [LW-1:0]          req_wdata_o, rsp_data_i;
  logic [LBY-1:0]         req_be_o;
  logic                   rsp_valid_i;

  gather_coalescer #(
    .LANES(LANES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .ELEM_BYTES(EBY), .LINE_BYTES(LBY)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .store_i(store_i), .base_i(base_i),
    .index_i(index_i), .mask_i(mask_i), .src_i(src_i), .busy_o(busy_o), .done_o(done_o),
    .dest_o(dest_o), .req_valid_o(req_valid_o), .req_ready_i(req_ready_i),
    .req_write_o(req_write_o), .req_line_addr_o(req_line_addr_o), .req_wdata_o(req_wdata_o),
    .req_be_o(req_be_o), .rsp_valid_i(rsp_valid_i), .rsp_data_i(rsp_data_i)
  );

  int checks = 0, errors = 0, total_cyc = 0;
  logic [7:0] mem [MEMSZ];
  logic [7:0] model [MEMSZ];
  logic [LANES*EW-1:0] exp_dest = '0;

  // cache model state
  logic [31:0] rs = 32'h1234_5677;
  bit  pend = 0;
  int  wait_c = 0, pend_line = 0, rq_cnt = 0;
  int  got_line [16];
  bit  got_wr [16];

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<%0d", total_cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Cache model: everything on the falling edge.
  always @(negedge clk) begin
    if (rst_n) begin
      rs = nxt(rs);
      req_ready_i = (rs[1:0] != 2'b00);
      rsp_valid_i = 1'b0;
      if (pend) begin
        if (wait_c == 0) begin
          for (int b = 0; b < LBY; b++) rsp_data_i[b*8 +: 8] = mem[pend_line + b];
          rsp_valid_i = 1'b1;
          pend = 0;
        end else wait_c--;
      end else if (req_valid_o && req_ready_i) begin
        if (rq_cnt < 16) begin
          got_line[rq_cnt] = int'(req_line_addr_o);
          got_wr[rq_cnt]   = req_write_o;
        end
        rq_cnt++;
        pend_line = int'(req_line_addr_o);
        if (req_write_o)
          for (int b = 0; b < LBY; b++)
            if (req_be_o[b]) mem[pend_line + b] = req_wdata_o[b*8 +: 8];
        pend = 1;
        wait_c = int'(rs[3:2]) % 3;
      end
    end
  end

  task automatic run_op(input bit st, input logic [ADDR_W-1:0] base,
                        input logic [LANES*IDX_W-1:0] ix, input logic [LANES-1:0] m,
                        input logic [LANES*EW-1:0] src, input bit poke);
    int wa [LANES];
    int exl [LANES];
    int nexp = 0, cyc = 0, bad = 0;
    logic [LANES-1:0] rem = m;
    for (int l = 0; l < LANES; l++)
      wa[l] = ((int'(base) >> 2) + int'($signed(ix[l*IDX_W +: IDX_W]))) & ((MEMSZ / EBY) - 1);
    while (rem != '0) begin
      int f = 0;
      for (int l = LANES - 1; l >= 0; l--) if (rem[l]) f = l;
      exl[nexp] = (wa[f] >> 2) * LBY;
      for (int l = 0; l < LANES; l++)
        if (rem[l] && (wa[l] >> 2) == (wa[f] >> 2)) rem[l] = 1'b0;
      nexp++;
    end
    for (int l = 0; l < LANES; l++) begin
      if (m[l]) begin
        if (st) for (int k = 0; k < EBY; k++) model[wa[l]*EBY + k] = src[l*EW + k*8 +: 8];
        else for (int k = 0; k < EBY; k++) exp_dest[l*EW + k*8 +: 8] = model[wa[l]*EBY + k];
      end
    end

    @(negedge clk);
    rq_cnt = 0;
    store_i = st; base_i = base; index_i = ix; mask_i = m; src_i = src; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (m == '0) begin
      check(done_o == 1'b1, "R7", "done after empty start", done_o, 1);
    end else begin
      check(busy_o == 1'b1, "R5", "busy after start", busy_o, 1);
      do begin
        @(negedge clk);
        cyc++;
        if (poke && cyc == 1) begin  // R9: stray start while busy
          start_i = 1'b1; store_i = ~st; mask_i = '1; base_i = ~base; index_i = ~ix;
        end else start_i = 1'b0;
      end while (!done_o && cyc < 400);
      check(cyc < 400, "R5", "done reached", cyc, 0);
    end
    check(rq_cnt == nexp, poke ? "R9" : "R3", "access count", rq_cnt, nexp);
    for (int i = 0; i < nexp && i < rq_cnt; i++) begin
      check(got_line[i] == exl[i], "R2", "line address", got_line[i], exl[i]);
      check(got_wr[i] == st, "R6", "write flag", got_wr[i], st);
    end
    for (int l = 0; l < LANES; l++)
      check(dest_o[l*EW +: EW] == exp_dest[l*EW +: EW], st ? "R6" : "R4", "dest lane",
            dest_o[l*EW +: EW], exp_dest[l*EW +: EW]);
    if (st) begin
      for (int a = 0; a < MEMSZ; a++) if (mem[a] !== model[a]) bad++;
      check(bad == 0, "R6", "memory bytes differing", bad, 0);
    end
    @(negedge clk);
    check(!busy_o && !done_o, "R5", "idle after done", {busy_o, done_o}, 0);
  endtask

  initial begin
    logic [31:0] r = 32'hACE1_2468;
    logic [LANES*IDX_W-1:0] ix;
    logic [LANES*EW-1:0] src;
    for (int a = 0; a < MEMSZ; a++) begin
      mem[a] = 8'(a * 37 + 11);
      model[a] = mem[a];
    end
    rst_n = 1'b0; start_i = 1'b0; store_i = 1'b0; base_i = '0; index_i = '0;
    mask_i = '0; src_i = '0; req_ready_i = 1'b0; rsp_valid_i = 1'b0; rsp_data_i = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy_o && !done_o && !req_valid_o, "R5", "reset outputs",
          {busy_o, done_o, req_valid_o}, 0);
    check(dest_o == '0, "R4", "reset dest", dest_o[63:0], 0);

    // R7: empty mask
    run_op(1'b0, 10'd64, '0, 8'h00, '0, 1'b0);
    // R3: eight consecutive words, two lines
    for (int l = 0; l < LANES; l++) ix[l*IDX_W +: IDX_W] = IDX_W'(l);
    run_op(1'b0, 10'd64, ix, 8'hFF, '0, 1'b0);
    // R3: stride of one line, eight accesses
    for (int l = 0; l < LANES; l++) ix[l*IDX_W +: IDX_W] = IDX_W'(4 * l);
    run_op(1'b0, 10'd3, ix, 8'hFF, '0, 1'b0);
    // R6: all lanes to one word, highest lane wins
    for (int l = 0; l < LANES; l++) src[l*EW +: EW] = 32'hA000_0000 + 32'(l);
    run_op(1'b1, 10'd200, '0, 8'hFF, src, 1'b0);
    run_op(1'b0, 10'd200, '0, 8'h01, '0, 1'b0);
    // R1: negative indices wrap; R9: stray start
    for (int l = 0; l < LANES; l++) ix[l*IDX_W +: IDX_W] = IDX_W'(-(l + 1));
    run_op(1'b0, 10'd8, ix, 8'hA5, '0, 1'b1);

    // Sweep
    for (int n = 0; n < 400; n++) begin
      r = nxt(r);
      for (int l = 0; l < LANES; l++) begin
        logic [31:0] q;
        q = nxt(r ^ 32'(l * 977));
        unique case (r[20:19])
          2'd0: ix[l*IDX_W +: IDX_W] = q[IDX_W-1:0];
          2'd1: ix[l*IDX_W +: IDX_W] = IDX_W'(l);
          2'd2: ix[l*IDX_W +: IDX_W] = IDX_W'(q[1:0]);
          default: ix[l*IDX_W +: IDX_W] = IDX_W'(LANES - 1 - l);
        endcase
        src[l*EW +: EW] = nxt(q);
      end
      run_op(r[0], r[10:1], ix, (r[23:21] == 3'd0) ? 8'h00 : r[18:11], src, r[24] & r[25]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule